// File: doc/BRIEF.md
# Dual-Channel DMA Control Register File

This block is the software-visible register file that steers two DMA channels: one serving a disk controller and one serving a network controller. A CPU reaches it over a simple single-cycle write / combinational read bus. The block holds each channel's control and status word, the disk channel's address counter, and five plain scratch words. It also drives one interrupt line per channel and a one-cycle reset pulse toward each attached peripheral.

Writes to the two control words are not stored verbatim. The version field is forced in. On the disk control word, the drain bit is also adjusted. A write to the disk address register also marks the disk control word as loaded. The disk transfer engine is outside this block. It reports each finished transfer with a byte length, and the block then flags the interrupt and advances the address counter. A separate raise/clear pair drives the disk interrupt directly. A request input raises the network interrupt.

Top module: `dma_ctl_regfile`

## Requirements
- R1: After reset, register 0 (disk control) and register 4 (network control) read 0xA0000000, every other register reads 0, and both interrupt lines and both reset pulses are low.
- R2: The register index is bits 4:2 of the byte address (address AND 31, shifted right by 2), so the eight registers repeat every 32 bytes.
- R3: Any write to register 0 or register 4 stores the version value 0xA in bits 31:28, whatever the written bits 31:28 were.
- R4: On a register-0 write with bit 7 clear, a written bit 6 is stored as 0, and an all-zero value is stored as 0x40 before the version field is applied. With bit 7 set, bit 6 is stored as written.
- R5: A write to register 1 stores the value and sets bit 26 (loaded) of register 0 on the same clock edge.
- R6: A completion strobe with a byte length sets bit 0 (pending) of register 0 and adds the length to register 1. If a register-0 write occurs in the same cycle, the write is applied first and bit 0 is then set. If a register-1 write occurs in the same cycle, the length is added to the written value.
- R7: The raise input sets bit 0 of register 0 and asserts the disk interrupt line. The clear input clears both. When both are active, clear wins.
- R8: A register-0 write with bit 4 (interrupt enable) clear deasserts the disk interrupt line. A register-4 write with bit 4 clear deasserts the network interrupt line. A raise request in the same cycle overrides the deassertion. The network request input asserts the network line.
- R9: A write with bit 7 set to register 0 gives a disk reset pulse, and one to register 4 gives a network reset pulse. Each pulse is high for exactly the one cycle after the write edge.
- R10: Registers 2, 3, 5, 6 and 7 store written values unmodified. A completion strobe does not change the disk interrupt line. Reads change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register, combinational |
| done_valid | input | 1 | Disk transfer completion strobe |
| done_len | input | LEN_W | Byte length of the completed transfer |
| irq_raise | input | 1 | Raise the disk interrupt |
| irq_clear | input | 1 | Clear the disk interrupt |
| net_irq_req | input | 1 | Network peripheral interrupt request |
| disk_irq | output | 1 | Disk channel interrupt line |
| net_irq | output | 1 | Network channel interrupt line |
| disk_rst_pulse | output | 1 | One-cycle reset pulse to the disk peripheral |
| net_rst_pulse | output | 1 | One-cycle reset pulse to the network peripheral |

## Verification
Register contents update on the clock edge that samples a write, completion or raise/clear strobe. Because reads are combinational, a register's new value is visible at the read port within that same cycle after the edge. The interrupt lines and reset pulses are registered, so they also change on that edge. A reset pulse falls again one edge later. The bench drives every stimulus on a falling edge and samples on the next falling edge, which is half a cycle after the single rising edge that acts on it. Pulse width is confirmed by sampling again one full cycle later.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  localparam int REG_W       = 32;
  localparam int NUM_REGS    = 8;
  localparam int IDX_W       = $clog2(NUM_REGS);
  localparam logic [3:0] VERSION = 4'hA;

  localparam int IDX_DISK_CTL  = 0;
  localparam int IDX_DISK_ADDR = 1;
  localparam int IDX_NET_CTL   = 4;

  localparam int BIT_PEND   = 0;
  localparam int BIT_IEN    = 4;
  localparam int BIT_DRAIN  = 6;
  localparam int BIT_RESET  = 7;
  localparam int BIT_LOADED = 26;

  localparam logic [REG_W-1:0] CTL_RESET_VAL = {VERSION, {(REG_W-4){1'b0}}};
endpackage

// File: rtl/dma_ctl_decode.sv
module dma_ctl_decode
  import dma_ctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  output logic [IDX_W-1:0]    idx,
  output logic [NUM_REGS-1:0] wr_sel
);
  assign idx = bus_addr[IDX_W+1:2];

  always_comb begin
    wr_sel = '0;
    if (bus_wr) wr_sel[idx] = 1'b1;
  end
endmodule

// File: rtl/dma_ctl_word_fix.sv
module dma_ctl_word_fix
  import dma_ctl_pkg::*;
#(
  parameter bit DRAIN_RULE = 1'b1
) (
  input  logic [REG_W-1:0] raw,
  output logic [REG_W-1:0] fixed
);
  logic [REG_W-1:0] mid;

  generate
    if (DRAIN_RULE) begin : g_drain
      always_comb begin
        mid = raw;
        if (!raw[BIT_RESET]) begin
          if (raw[BIT_DRAIN])   mid[BIT_DRAIN] = 1'b0;
          else if (raw == '0)   mid[BIT_DRAIN] = 1'b1;
        end
      end
    end else begin : g_plain
      assign mid = raw;
    end
  endgenerate

  assign fixed = {VERSION, mid[REG_W-5:0]};
endmodule

// File: rtl/dma_ctl_chan_line.sv
module dma_ctl_chan_line
  import dma_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ctl_ien,
  input  logic ctl_reset,
  input  logic raise,
  input  logic clear,
  output logic irq,
  output logic rst_pulse
);
  logic irq_d, pulse_d;

  always_comb begin
    irq_d = irq;
    if (ctl_wr && !ctl_ien) irq_d = 1'b0;
    if (raise)              irq_d = 1'b1;
    if (clear)              irq_d = 1'b0;
    pulse_d = ctl_wr && ctl_reset;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq       <= 1'b0;
      rst_pulse <= 1'b0;
    end else begin
      irq       <= irq_d;
      rst_pulse <= pulse_d;
    end
  end
endmodule

// File: rtl/dma_ctl_regfile.sv
module dma_ctl_regfile
  import dma_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              done_valid,
  input  logic [LEN_W-1:0]  done_len,
  input  logic              irq_raise,
  input  logic              irq_clear,
  input  logic              net_irq_req,
  output logic              disk_irq,
  output logic              net_irq,
  output logic              disk_rst_pulse,
  output logic              net_rst_pulse
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [IDX_W-1:0]    idx;
  logic [NUM_REGS-1:0] wr_sel;

  dma_ctl_decode #(.ADDR_W(ADDR_W)) i_decode (
    .bus_wr (bus_wr),
    .bus_addr (bus_addr),
    .idx    (idx),
    .wr_sel (wr_sel)
  );

  logic [REG_W-1:0] disk_fix, net_fix;

  dma_ctl_word_fix #(.DRAIN_RULE(1'b1)) i_fix_disk (
    .raw (bus_wdata), .fixed (disk_fix)
  );
  dma_ctl_word_fix #(.DRAIN_RULE(1'b0)) i_fix_net (
    .raw (bus_wdata), .fixed (net_fix)
  );

  logic [REG_W-1:0] disk_ctl_q, disk_ctl_d;
  logic [REG_W-1:0] disk_addr_q, disk_addr_d;
  logic [REG_W-1:0] net_ctl_q, net_ctl_d;
  logic [REG_W-1:0] base_addr;
  logic [REG_W-1:0] regs_view [NUM_REGS];

  always_comb begin
    disk_ctl_d = disk_ctl_q;
    if (wr_sel[IDX_DISK_CTL])  disk_ctl_d = disk_fix;
    if (wr_sel[IDX_DISK_ADDR]) disk_ctl_d[BIT_LOADED] = 1'b1;
    if (done_valid)            disk_ctl_d[BIT_PEND] = 1'b1;
    if (irq_raise)             disk_ctl_d[BIT_PEND] = 1'b1;
    if (irq_clear)             disk_ctl_d[BIT_PEND] = 1'b0;

    base_addr   = wr_sel[IDX_DISK_ADDR] ? bus_wdata : disk_addr_q;
    disk_addr_d = base_addr;
    if (done_valid)
      disk_addr_d = base_addr + {{(REG_W-LEN_W){1'b0}}, done_len};

    net_ctl_d = wr_sel[IDX_NET_CTL] ? net_fix : net_ctl_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      disk_ctl_q  <= CTL_RESET_VAL;
      disk_addr_q <= '0;
      net_ctl_q   <= CTL_RESET_VAL;
    end else begin
      disk_ctl_q  <= disk_ctl_d;
      disk_addr_q <= disk_addr_d;
      net_ctl_q   <= net_ctl_d;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REGS; gi++) begin : g_reg
      if (gi == IDX_DISK_CTL) begin : g_dc
        assign regs_view[gi] = disk_ctl_q;
      end else if (gi == IDX_DISK_ADDR) begin : g_da
        assign regs_view[gi] = disk_addr_q;
      end else if (gi == IDX_NET_CTL) begin : g_nc
        assign regs_view[gi] = net_ctl_q;
      end else begin : g_plain
        logic [REG_W-1:0] plain_q, plain_d;
        always_comb plain_d = wr_sel[gi] ? bus_wdata : plain_q;
        always_ff @(posedge clk or negedge rst_int_n) begin
          if (!rst_int_n) plain_q <= '0;
          else            plain_q <= plain_d;
        end
        assign regs_view[gi] = plain_q;
      end
    end
  endgenerate

  assign bus_rdata = regs_view[idx];

  dma_ctl_chan_line i_disk_line (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ctl_wr    (wr_sel[IDX_DISK_CTL]),
    .ctl_ien   (bus_wdata[BIT_IEN]),
    .ctl_reset (bus_wdata[BIT_RESET]),
    .raise     (irq_raise),
    .clear     (irq_clear),
    .irq       (disk_irq),
    .rst_pulse (disk_rst_pulse)
  );

  dma_ctl_chan_line i_net_line (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ctl_wr    (wr_sel[IDX_NET_CTL]),
    .ctl_ien   (bus_wdata[BIT_IEN]),
    .ctl_reset (bus_wdata[BIT_RESET]),
    .raise     (net_irq_req),
    .clear     (1'b0),
    .irq       (net_irq),
    .rst_pulse (net_rst_pulse)
  );
endmodule

// File: rtl/dma_ctl_regfile_chk.sv
module dma_ctl_regfile_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              irq_raise,
  input logic              irq_clear,
  input logic              net_irq_req,
  input logic              disk_irq,
  input logic              net_irq,
  input logic              disk_rst_pulse,
  input logic [31:0]       disk_ctl
);
  logic [2:0] a_idx;
  assign a_idx = bus_addr[4:2];

  assert_ver_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_idx == 3'd0 || a_idx == 3'd4) |-> bus_rdata[31:28] == 4'hA);

  assert_loaded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && a_idx == 3'd1) |=> disk_ctl[26]);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clear |=> (!disk_irq && !disk_ctl[0]));

  assert_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_raise && !irq_clear) |=> disk_irq);

  assert_net_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && a_idx == 3'd4 && !bus_wdata[4] && !net_irq_req) |=> !net_irq);

  assert_pulse_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    disk_rst_pulse |-> $past(bus_wr && a_idx == 3'd0 && bus_wdata[7]));
endmodule

bind dma_ctl_regfile dma_ctl_regfile_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bus_wr         (bus_wr),
  .bus_addr       (bus_addr),
  .bus_wdata      (bus_wdata),
  .bus_rdata      (bus_rdata),
  .irq_raise      (irq_raise),
  .irq_clear      (irq_clear),
  .net_irq_req    (net_irq_req),
  .disk_irq       (disk_irq),
  .net_irq        (net_irq),
  .disk_rst_pulse (disk_rst_pulse),
  .disk_ctl       (disk_ctl_q)
);

// File: tb/test_dma_ctl_regfile.sv
`timescale 1ns/1ps
module test_dma_ctl_regfile;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        done_valid;
  logic [15:0] done_len;
  logic        irq_raise, irq_clear, net_irq_req;
  logic        disk_irq, net_irq, disk_rst_pulse, net_rst_pulse;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma_ctl_regfile i_dma_ctl_regfile (
    .clk (clk), .rst_n (rst_n),
    .bus_wr (bus_wr), .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .done_valid (done_valid), .done_len (done_len),
    .irq_raise (irq_raise), .irq_clear (irq_clear), .net_irq_req (net_irq_req),
    .disk_irq (disk_irq), .net_irq (net_irq),
    .disk_rst_pulse (disk_rst_pulse), .net_rst_pulse (net_rst_pulse)
  );

  // {write addr, write data, read addr, expected read}
  localparam int NV = 11;
  localparam logic [79:0] VEC [NV] = '{
    {8'h00, 32'h0000_0010, 8'h00, 32'hA000_0010}, // R3
    {8'h00, 32'h0000_0000, 8'h00, 32'hA000_0040}, // R4 zero
    {8'h00, 32'h0000_0040, 8'h00, 32'hA000_0000}, // R4 drain bit cleared
    {8'h00, 32'hF000_00C0, 8'h00, 32'hA000_00C0}, // R4 bit7 keeps bit6, R3
    {8'h08, 32'h1234_5678, 8'h08, 32'h1234_5678}, // R10
    {8'h28, 32'hCAFE_F00D, 8'h08, 32'hCAFE_F00D}, // R2 alias
    {8'h10, 32'h5000_0005, 8'h10, 32'hA000_0005}, // R3 network word
    {8'h1C, 32'hFFFF_FFFF, 8'h1C, 32'hFFFF_FFFF}, // R10
    {8'h04, 32'h0000_1000, 8'h00, 32'hA400_00C0}, // R5 loaded flag
    {8'h04, 32'h0000_1000, 8'h24, 32'h0000_1000}, // R5 stored, R2 alias read
    {8'h00, 32'h0000_0000, 8'h00, 32'hA000_0040}  // R4 rewrite clears loaded
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    done_valid = 1'b0; done_len = '0;
    irq_raise = 1'b0; irq_clear = 1'b0; net_irq_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      rd(8'(i * 4), v);
      chk("R1 reset value", v, (i == 0 || i == 4) ? 32'hA000_0000 : 32'h0);
    end
    chk("R1 irq/pulse low", {28'h0, disk_irq, net_irq, disk_rst_pulse, net_rst_pulse}, 32'h0);

    for (int n = 0; n < NV; n++) begin
      wr(VEC[n][79:72], VEC[n][71:40]);
      rd(VEC[n][39:32], v);
      chk($sformatf("table row %0d (R2 R3 R4 R5 R10)", n), v, VEC[n][31:0]);
    end

    // R6 completion: addr 0x1000 + 0x20, pending set, line unaffected (R10)
    @(negedge clk); done_valid = 1'b1; done_len = 16'h0020;
    @(negedge clk); done_valid = 1'b0;
    rd(8'h04, v); chk("R6 address advance", v, 32'h0000_1020);
    rd(8'h00, v); chk("R6 pending set", v, 32'hA000_0041);
    chk("R10 completion leaves line", {31'h0, disk_irq}, 32'h0);

    // R6 same-cycle register-0 write and completion
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h10;
    done_valid = 1'b1; done_len = 16'h0004;
    @(negedge clk); bus_wr = 1'b0; done_valid = 1'b0;
    rd(8'h00, v); chk("R6 write then pending", v, 32'hA000_0011);
    rd(8'h04, v); chk("R6 length added", v, 32'h0000_1024);

    // R6 same-cycle register-1 write and completion
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h200;
    done_valid = 1'b1; done_len = 16'h0010;
    @(negedge clk); bus_wr = 1'b0; done_valid = 1'b0;
    rd(8'h04, v); chk("R6 length on written address", v, 32'h0000_0210);

    // R7 raise then clear
    @(negedge clk); irq_raise = 1'b1;
    @(negedge clk); irq_raise = 1'b0;
    chk("R7 raise line", {31'h0, disk_irq}, 32'h1);
    rd(8'h00, v); chk("R7 raise pending", {31'h0, v[0]}, 32'h1);
    @(negedge clk); irq_clear = 1'b1; irq_raise = 1'b1;
    @(negedge clk); irq_clear = 1'b0; irq_raise = 1'b0;
    chk("R7 clear wins line", {31'h0, disk_irq}, 32'h0);
    rd(8'h00, v); chk("R7 clear pending", {31'h0, v[0]}, 32'h0);

    // R8 enable bit behaviour on disk line
    @(negedge clk); irq_raise = 1'b1;
    @(negedge clk); irq_raise = 1'b0;
    wr(8'h00, 32'h0000_0010);
    chk("R8 enable set keeps disk line", {31'h0, disk_irq}, 32'h1);
    wr(8'h00, 32'h0000_0001);
    chk("R8 enable clear drops disk line", {31'h0, disk_irq}, 32'h0);

    // R8 network line
    @(negedge clk); net_irq_req = 1'b1;
    @(negedge clk); net_irq_req = 1'b0;
    chk("R8 network request", {31'h0, net_irq}, 32'h1);
    wr(8'h10, 32'h0000_0010);
    chk("R8 network enable keeps", {31'h0, net_irq}, 32'h1);
    wr(8'h30, 32'h0000_0000);
    chk("R8 network enable clear", {31'h0, net_irq}, 32'h0);

    // R9 reset pulses
    wr(8'h00, 32'h0000_0080);
    chk("R9 disk pulse high", {30'h0, disk_rst_pulse, net_rst_pulse}, 32'h2);
    @(negedge clk);
    chk("R9 disk pulse one cycle", {31'h0, disk_rst_pulse}, 32'h0);
    wr(8'h10, 32'h0000_0090);
    chk("R9 network pulse high", {30'h0, disk_rst_pulse, net_rst_pulse}, 32'h1);
    @(negedge clk);
    chk("R9 network pulse one cycle", {31'h0, net_rst_pulse}, 32'h0);
    rd(8'h10, v); chk("R3 network word kept", v, 32'hA000_0090);

    // R10 reads have no side effect
    rd(8'h18, v); rd(8'h18, v);
    chk("R10 read stable", v, 32'h0);
    rd(8'h04, v); chk("R10 address unchanged by reads", v, 32'h0000_0210);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule